// File: doc/BRIEF.md
# Supply, Manual and Watchdog Reset Supervisor

This block builds one system reset out of three causes: a supply-good flag that has already passed through a comparator with hysteresis, an active-low manual reset request, and a watchdog input that software must keep toggling. Any cause asserts the reset output. After the last cause goes away, one shared hold timer keeps the output asserted for a fixed number of clock cycles before releasing it.

The watchdog counts clock cycles in which its synchronised input has not changed level. Either edge of that input restarts the count. While reset is asserted, the count is held at zero. If the input stays at one level for the whole timeout window, the watchdog raises a one-cycle cause, so a watchdog reset lasts exactly the hold time. A sticky flag records that the latest reset came from the watchdog. The polarity of the output is chosen by a parameter. The manual and watchdog inputs are asynchronous and each passes through a two-flop synchroniser. The supply-good flag must already be synchronous to the clock.

Top module: `rst_supervisor`

## Requirements
- R1: When `supply_ok_i` is low at a rising clock edge, the reset is asserted right after that edge.
- R2: After the last edge at which any cause is present, the reset stays asserted through HOLD_CYC clock edges, counting that edge as the first. It is then released.
- R3: The manual request `man_rst_ni` reaches the cause logic after two synchroniser flops. A low level driven before edge k asserts the reset after edge k+2. The same latency applies on release.
- R4: If the synchronised watchdog input shows no level change for TIMEOUT_CYC cycles while the reset is released, a watchdog reset is raised. That reset stays asserted for exactly HOLD_CYC cycles.
- R5: A rising edge and a falling edge on `wdi_i` each restart the watchdog count. Toggling at intervals shorter than TIMEOUT_CYC − 2 cycles never causes a watchdog reset.
- R6: The watchdog count is held at zero while the reset is asserted, however long that lasts. After release with an idle input, the reset stays released for exactly TIMEOUT_CYC cycles before the watchdog reset.
- R7: With POLARITY = POL_LOW, `rst_o` is 0 while asserted. With POL_HIGH, `rst_o` is 1 while asserted.
- R8: `wd_cause_o` is set together with a watchdog-raised reset. It is cleared by a supply or manual cause and by the power-on reset. Otherwise it holds its value.
- R9: A cause that appears while the hold timer is running restarts the full HOLD_CYC interval.
- R10: While `por_ni` is low, the reset is asserted and `wd_cause_o` is 0. After `por_ni` goes high with no cause present, the reset stays asserted for HOLD_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| supply_ok_i | input | 1 | Supply-good flag, synchronous, low means the supply is under threshold |
| man_rst_ni | input | 1 | Manual reset request, active low, asynchronous |
| wdi_i | input | 1 | Watchdog kick input, asynchronous, either edge counts |
| rst_o | output | 1 | Reset output, polarity set by POLARITY |
| wd_cause_o | output | 1 | Sticky flag: the latest reset was raised by the watchdog |

## Verification
The bench drives the supply flag and the manual input with pulses of several lengths, and measures how many cycles the reset stays asserted. This separates a correct hold and synchroniser latency from off-by-one and missing-restart faults. A second pulse placed inside the hold window shows whether the timer restarts.

The watchdog input is tried three ways: held still after a short reset, held still after a reset much longer than the timeout, and toggled at a period whose gap between two same-direction edges exceeds the timeout. The first tells a zero-based restart from a stale count. The second shows whether the count is cleared during reset. The third catches a watchdog that reacts to only one edge direction. A second instance with the other polarity runs alongside and is compared on every cycle.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } rst_pol_e;

    typedef struct packed {
        logic supply;
        logic manual;
        logic wdog;
    } cause_t;

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int unsigned      WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = d_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.meta   <= RST_VAL;
            st_q.stable <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.stable;

endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog #(
    parameter int unsigned TIMEOUT_CYC = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic kick_i,
    input  logic hold_clr_i,
    output logic fire_o
);

    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] idle;
    } wdog_t;

    wdog_t st_d, st_q;
    logic  edge_seen;
    logic  fire;

    always_comb begin
        edge_seen = kick_i ^ st_q.prev;
        fire      = !hold_clr_i && !edge_seen && (st_q.idle == LAST);
        st_d.prev = kick_i;
        if (hold_clr_i || edge_seen || fire) begin
            st_d.idle = '0;
        end else begin
            st_d.idle = st_q.idle + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.prev <= 1'b0;
            st_q.idle <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = fire;

endmodule

// File: rtl/rsup_hold.sv
module rsup_hold #(
    parameter int unsigned HOLD_CYC = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_cause_i,
    input  logic wd_fire_i,
    output logic asrt_o,
    output logic wd_flag_o
);

    localparam int unsigned HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

    typedef struct packed {
        logic          asrt;
        logic          flag;
        logic [HW-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ext_cause_i || wd_fire_i) begin
            st_d.asrt = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.asrt) begin
            if (st_q.cnt == LAST) begin
                st_d.asrt = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + HW'(1);
            end
        end
        if (ext_cause_i) begin
            st_d.flag = 1'b0;
        end else if (wd_fire_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.asrt <= 1'b1;
            st_q.flag <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign asrt_o    = st_q.asrt;
    assign wd_flag_o = st_q.flag;

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsup_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1000,
    parameter int unsigned HOLD_CYC    = 200,
    parameter rst_pol_e    POLARITY    = POL_LOW
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic supply_ok_i,
    input  logic man_rst_ni,
    input  logic wdi_i,
    output logic rst_o,
    output logic wd_cause_o
);

    // bit 0: manual request (idle high), bit 1: watchdog kick
    localparam logic [1:0] SYNC_RST = 2'b01;

    logic [1:0] raw_in;
    logic [1:0] sync_in;
    cause_t     cause;
    logic       wd_fire;
    logic       asrt;

    assign raw_in = {wdi_i, man_rst_ni};

    rsup_sync #(
        .WIDTH  (2),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(por_ni),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    rsup_wdog #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_wdog (
        .clk_i     (clk_i),
        .rst_ni    (por_ni),
        .kick_i    (sync_in[1]),
        .hold_clr_i(asrt),
        .fire_o    (wd_fire)
    );

    always_comb begin
        cause.supply = !supply_ok_i;
        cause.manual = !sync_in[0];
        cause.wdog   = wd_fire;
    end

    rsup_hold #(
        .HOLD_CYC(HOLD_CYC)
    ) u_hold (
        .clk_i      (clk_i),
        .rst_ni     (por_ni),
        .ext_cause_i(cause.supply | cause.manual),
        .wd_fire_i  (cause.wdog),
        .asrt_o     (asrt),
        .wd_flag_o  (wd_cause_o)
    );

    generate
        if (POLARITY == POL_HIGH) begin : g_out_hi
            assign rst_o = asrt;
        end else begin : g_out_lo
            assign rst_o = ~asrt;
        end
    endgenerate

endmodule

// File: rtl/rsup_checker.sv
module rsup_checker
    import rsup_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1000,
    parameter int unsigned HOLD_CYC    = 200,
    parameter rst_pol_e    POLARITY    = POL_LOW
) (
    input logic clk_i,
    input logic por_ni,
    input logic supply_ok_i,
    input logic man_rst_ni,
    input logic wdi_i,
    input logic rst_o,
    input logic wd_cause_o
);

    logic asrt;
    int unsigned run_q;
    int unsigned idle_q;
    logic wdi_prev_q;

    assign asrt = (POLARITY == POL_HIGH) ? rst_o : !rst_o;

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            run_q      <= 0;
            idle_q     <= 0;
            wdi_prev_q <= 1'b0;
        end else begin
            wdi_prev_q <= wdi_i;
            if (asrt) begin
                run_q <= (run_q < HOLD_CYC) ? run_q + 1 : run_q;
            end else begin
                run_q <= 0;
            end
            if (asrt || (wdi_i != wdi_prev_q)) begin
                idle_q <= 0;
            end else if (idle_q < TIMEOUT_CYC + 8) begin
                idle_q <= idle_q + 1;
            end
        end
    end

    // R1
    supply_low_asserts_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        !supply_ok_i |=> asrt);

    // R8
    flag_cleared_by_supply_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        !supply_ok_i |=> !wd_cause_o);

    // R8
    flag_rises_with_reset_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        $rose(wd_cause_o) |-> asrt);

    // R2
    hold_min_len_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        $fell(asrt) |-> (run_q >= HOLD_CYC));

    // R4
    kick_gap_bound_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        idle_q <= TIMEOUT_CYC + 3);

    // R3
    manual_low_asserts_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        (!man_rst_ni && $past(!man_rst_ni) && $past(!man_rst_ni, 2)) |=> asrt);

endmodule

bind rst_supervisor rsup_checker #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .POLARITY   (POLARITY)
) u_rsup_checker (
    .clk_i      (clk_i),
    .por_ni     (por_ni),
    .supply_ok_i(supply_ok_i),
    .man_rst_ni (man_rst_ni),
    .wdi_i      (wdi_i),
    .rst_o      (rst_o),
    .wd_cause_o (wd_cause_o)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;

    localparam int T = 40;
    localparam int H = 10;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic supply_ok = 1'b1;
    logic mr_n = 1'b1;
    logic wdi = 1'b0;
    logic rst_lo, rst_hi, flag_lo, flag_hi;

    logic kick_en = 1'b0;
    int   kick_per = 8;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    rst_supervisor #(.TIMEOUT_CYC(T), .HOLD_CYC(H), .POLARITY(rsup_pkg::POL_LOW)) i_rst_supervisor (
        .clk_i(clk), .por_ni(por_n), .supply_ok_i(supply_ok), .man_rst_ni(mr_n),
        .wdi_i(wdi), .rst_o(rst_lo), .wd_cause_o(flag_lo));

    rst_supervisor #(.TIMEOUT_CYC(T), .HOLD_CYC(H), .POLARITY(rsup_pkg::POL_HIGH)) i_rst_supervisor_hi (
        .clk_i(clk), .por_ni(por_n), .supply_ok_i(supply_ok), .man_rst_ni(mr_n),
        .wdi_i(wdi), .rst_o(rst_hi), .wd_cause_o(flag_hi));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_left;
    bit  m_asrt, m_flag;
    bit  m_pipe_m[$];
    bit  m_pipe_w[$];
    bit  m_wlast;
    int  m_quiet;

    task automatic model_reset();
        m_asrt = 1'b1; m_left = H; m_flag = 1'b0;
        m_pipe_m = '{1'b1, 1'b1};
        m_pipe_w = '{1'b0, 1'b0};
        m_wlast = 1'b0; m_quiet = 0;
    endtask

    initial model_reset();

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            model_reset();
        end else begin
            bit mr_seen, w_seen, moved, boom, ext;
            mr_seen = m_pipe_m[0];
            w_seen  = m_pipe_w[0];
            moved   = (w_seen != m_wlast);
            boom    = !m_asrt && !moved && (m_quiet == T - 1);
            ext     = !supply_ok || !mr_seen;
            void'(m_pipe_m.pop_front()); m_pipe_m.push_back(mr_n);
            void'(m_pipe_w.pop_front()); m_pipe_w.push_back(wdi);
            m_wlast = w_seen;
            m_quiet = (m_asrt || moved || boom) ? 0 : m_quiet + 1;
            if (ext || boom) begin
                m_asrt = 1'b1; m_left = H;
            end else if (m_asrt) begin
                m_left = m_left - 1;
                if (m_left == 0) m_asrt = 1'b0;
            end
            if (ext) m_flag = 1'b0;
            else if (boom) m_flag = 1'b1;
        end
    end

    // lockstep comparison, sampled away from the active edge
    always @(negedge clk) begin
        chk(rst_lo == !m_asrt, "R2 lockstep rst_o", int'(rst_lo), int'(!m_asrt));
        chk(flag_lo == m_flag, "R8 lockstep wd_cause_o", int'(flag_lo), int'(m_flag));
        chk(rst_hi == ~rst_lo, "R7 polarity pair", int'(rst_hi), int'(~rst_lo));
    end

    // watchdog kicker: the only driver of wdi
    initial begin
        int kc;
        kc = 0;
        forever begin
            @(negedge clk);
            if (kick_en) begin
                kc++;
                if (kc >= kick_per) begin
                    wdi = ~wdi;
                    kc = 0;
                end
            end else begin
                kc = 0;
            end
        end
    end

    function automatic bit asserted();
        return rst_lo == 1'b0;
    endfunction

    // counts consecutive samples (current one included) in the given state
    task automatic run_while(input bit want, output int n);
        n = 0;
        while (asserted() == want && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual 0 expected 1");
        finish_run();
    end

    initial begin
        int n;
        kick_per = 8;
        repeat (3) @(negedge clk);
        // R10 reset state, R7 both polarities
        chk(rst_lo == 1'b0, "R10 por asserted low-pol", int'(rst_lo), 0);
        chk(rst_hi == 1'b1, "R7 por asserted high-pol", int'(rst_hi), 1);
        chk(flag_lo == 1'b0, "R10 por flag", int'(flag_lo), 0);

        kick_en = 1'b1;
        por_n = 1'b1;
        run_while(1'b1, n);
        chk(n == H, "R10 hold after por", n, H);
        repeat (60) @(negedge clk);
        chk(!asserted(), "R5 kicked, stays released", int'(asserted()), 0);

        // supply drop of 5 cycles
        supply_ok = 1'b0;
        @(negedge clk);
        chk(asserted(), "R1 supply low asserts next edge", int'(asserted()), 1);
        repeat (4) @(negedge clk);
        supply_ok = 1'b1;
        run_while(1'b1, n);
        chk(n == H, "R2 hold after supply returns", n, H);

        // manual reset, synchroniser latency
        repeat (20) @(negedge clk);
        kick_en = 1'b0;
        mr_n = 1'b0;
        @(negedge clk);
        chk(!asserted(), "R3 not yet after one edge", int'(asserted()), 0);
        @(negedge clk);
        chk(!asserted(), "R3 not yet after two edges", int'(asserted()), 0);
        @(negedge clk);
        chk(asserted(), "R3 asserted after three edges", int'(asserted()), 1);
        repeat (3) @(negedge clk);
        mr_n = 1'b1;
        run_while(1'b1, n);
        chk(n == H + 2, "R3 release latency plus hold", n, H + 2);

        // idle watchdog after release
        run_while(1'b0, n);
        chk(n == T, "R6 released window before watchdog", n, T);
        chk(flag_lo == 1'b1, "R8 flag set by watchdog", int'(flag_lo), 1);
        run_while(1'b1, n);
        chk(n == H, "R4 watchdog reset length", n, H);

        // both edges kick, period gap T-4 between toggles
        kick_per = T - 4;
        kick_en = 1'b1;
        n = 0;
        for (int i = 0; i < 6 * T; i++) begin
            if (asserted()) n++;
            @(negedge clk);
        end
        chk(n == 0, "R5 rise and fall both restart", n, 0);
        chk(flag_lo == 1'b1, "R8 flag sticky", int'(flag_lo), 1);

        // retrigger inside the hold window
        supply_ok = 1'b0;
        @(negedge clk);
        chk(flag_lo == 1'b0, "R8 flag cleared by supply", int'(flag_lo), 0);
        supply_ok = 1'b1;
        repeat (5) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        run_while(1'b1, n);
        chk(n == H, "R9 hold restarts on new cause", n, H);

        // long reset with idle watchdog input
        repeat (10) @(negedge clk);
        kick_en = 1'b0;
        supply_ok = 1'b0;
        repeat (3 * T) @(negedge clk);
        chk(flag_lo == 1'b0, "R6 no watchdog fire during reset", int'(flag_lo), 0);
        supply_ok = 1'b1;
        run_while(1'b1, n);
        chk(n == H, "R2 hold after long drop", n, H);
        run_while(1'b0, n);
        chk(n == T, "R6 count restarts from zero", n, T);
        chk(rst_hi == 1'b1, "R7 high-pol asserted on watchdog", int'(rst_hi), 1);

        // manual request clears the flag
        mr_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(flag_lo == 1'b0, "R8 flag cleared by manual", int'(flag_lo), 0);
        mr_n = 1'b1;
        kick_en = 1'b1;
        kick_per = 8;
        repeat (H + 10) @(negedge clk);
        chk(!asserted(), "R2 released at end", int'(asserted()), 0);

        finish_run();
    end

endmodule